// File: doc/BRIEF.md
# Display Link Training Sequencer

This block brings up a DisplayPort-style main link from the source side. Given a payload bandwidth and the rate and lane limits of both ends, it picks the smallest lane count and the lowest line rate that still carry the payload. It writes that configuration to the sink and then trains the link in two phases: clock recovery first, channel equalisation second. If either phase fails at the higher rate, the whole attempt is repeated one rate lower. Training ends with the training pattern switched off and a one-cycle completion pulse that reports the outcome.

Every sink register access goes through an abstract AUX request port. The block holds a request (direction, address, length, write data) until the port answers with done, and an error flag arrives together with done. Per-lane voltage swing and pre-emphasis, taken from the sink's adjust requests, are driven to the transmitter on two packed output buses, along with the current training pattern. The wait before each status read is a cycle-count parameter (`CR_WAIT_CYC`, `EQ_WAIT_CYC`), so an integrator sets it to 100 µs and 400 µs of the local clock.

Top module: `link_trainer`

## Requirements
- R1: Out of reset, `done`, `pass` and `aux_req` are low, and `tx_pattern`, `tx_swing` and `tx_preemph` are zero.
- R2: The required bandwidth is (payload_kbs / 8) * 10. Training starts at rate code 10 (270000 kB/s) if the smaller of the two rate codes is at least 10, at code 6 (162000 kB/s) if it is at least 6, and otherwise ends at once with pass low. The lane count starts at the smaller lane limit (1, 2 or 4) and is halved while half the lanes times the rate is strictly above the requirement. If the rate is 270000 and 162000 times the lane count is strictly above the requirement, code 6 is used instead.
- R3: The link configuration is written to address 0x100 with length 2. Byte 0 (wdata[7:0]) is the rate code, and byte 1 is the lane count with bit 7 set when `sink_enh` is high.
- R4: The training pattern is written to address 0x102 with length 1: value 1 before clock recovery, 2 before equalisation, 0 at the end. `tx_pattern` holds the same value.
- R5: Each drive commit writes address 0x103 with length 4, one byte per lane (lane i in wdata[8i+7:8i]). The byte is {pre-emphasis, swing} placed as pre<<3 | swing, plus bit 2 when swing is 3 and bit 5 when pre-emphasis is 3. The values come from the adjust nibbles in status bytes 4 and 5 (lane i at rdata[32+4i+3:32+4i], swing in bits 1:0, pre-emphasis in bits 3:2). Inactive lanes read 0, and `tx_swing`/`tx_preemph` carry 2 bits per lane. The first commit of each rate uses all-zero settings.
- R6: Status is read from address 0x202 with length 6. Lane i's nibble is rdata[4i+3:4i], with bit 0 meaning clock recovered, bit 1 equalised and bit 2 symbol locked; rdata[16] means interlane aligned. A clock-recovery read is requested `CR_WAIT_CYC` cycles after the commit completes, and an equalisation read `EQ_WAIT_CYC` cycles after the pattern write or the commit completes.
- R7: Clock recovery succeeds when every active lane reports bit 0, and training moves on to equalisation.
- R8: Clock recovery fails, and training falls back, when the first active lane without bit 0 has its max-swing flag set in the last commit. It also fails after 5 tries at an unchanged lane-0 swing; a change of lane-0 swing restarts that count.
- R9: Equalisation succeeds when the link is aligned and every active lane has bits 0, 1 and 2 set. A commit follows the read, then pattern 0 is written, and `pass` is reported high.
- R10: Equalisation fails when any active lane loses bit 0 or after 6 tries. Each try is a read followed by a commit.
- R11: After a failure at code 10, training restarts at code 6 with the lane count chosen again for that rate. A failure at code 6 ends training with pass low after pattern 0 is written.
- R12: An AUX error on a drive commit or a status read fails the current phase.
- R13: `done` is a one-cycle pulse in the cycle after the final pattern write completes. `link_rate_code` (10, 6, or 0 when no rate applies), `link_lanes` and `pass` are valid with it.
- R14: `aux_req` stays high, with address and direction unchanged, until `aux_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (taken while idle) |
| payload_kbs | input | 32 | Payload bandwidth in kB/s |
| src_rate_code | input | 8 | Source rate limit (rate / 27000) |
| sink_rate_code | input | 8 | Sink rate limit (rate / 27000) |
| src_lanes | input | 3 | Source lane limit (1, 2, 4) |
| sink_lanes | input | 3 | Sink lane limit (1, 2, 4) |
| sink_enh | input | 1 | Sink supports enhanced framing |
| aux_req | output | 1 | AUX request, held until done |
| aux_write | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 16 | Sink register address |
| aux_len | output | 3 | Transfer length in bytes |
| aux_wdata | output | 32 | Write bytes, first byte in bits 7:0 |
| aux_done | input | 1 | AUX transfer finished |
| aux_err | input | 1 | AUX transfer failed (valid with done) |
| aux_rdata | input | 48 | Read bytes, first byte in bits 7:0 |
| tx_pattern | output | 2 | Training pattern to transmitter |
| tx_swing | output | 8 | Swing level, 2 bits per lane |
| tx_preemph | output | 8 | Pre-emphasis level, 2 bits per lane |
| done | output | 1 | Training finished pulse |
| pass | output | 1 | Training succeeded |
| link_rate_code | output | 8 | Rate code in use |
| link_lanes | output | 3 | Lane count in use |

## Verification
The bench's AUX responder stamps the cycle of every request and every completion. A clock-recovery status read must appear exactly `CR_WAIT_CYC`+1 responder cycles after the preceding commit completed, and an equalisation read `EQ_WAIT_CYC`+1 cycles after the pattern write completed. `done` must be seen one cycle after the final pattern write completes. Every other result is compared only after `done`, against the logged sequence of AUX transactions: counts of commits between configuration writes, data of particular commits, and the final rate and lanes. No check depends on the cycle in which an intermediate register changes.

// File: rtl/link_trainer.sv
module link_trainer #(
  parameter int CR_WAIT_CYC = 100,
  parameter int EQ_WAIT_CYC = 400,
  parameter int CR_TRIES    = 5,
  parameter int EQ_TRIES    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] payload_kbs,
  input  logic [7:0]  src_rate_code,
  input  logic [7:0]  sink_rate_code,
  input  logic [2:0]  src_lanes,
  input  logic [2:0]  sink_lanes,
  input  logic        sink_enh,
  output logic        aux_req,
  output logic        aux_write,
  output logic [15:0] aux_addr,
  output logic [2:0]  aux_len,
  output logic [31:0] aux_wdata,
  input  logic        aux_done,
  input  logic        aux_err,
  input  logic [47:0] aux_rdata,
  output logic [1:0]  tx_pattern,
  output logic [7:0]  tx_swing,
  output logic [7:0]  tx_preemph,
  output logic        done,
  output logic        pass,
  output logic [7:0]  link_rate_code,
  output logic [2:0]  link_lanes
);
  localparam int TW = $clog2(CR_WAIT_CYC + EQ_WAIT_CYC + 1);
  localparam int NW = $clog2(CR_TRIES + EQ_TRIES + 1);
  localparam logic [35:0] HI_KBS = 36'd270000;
  localparam logic [35:0] LO_KBS = 36'd162000;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_CFG, S_TP, S_CRC, S_CRW, S_CRR, S_CRE,
    S_EQW, S_EQR, S_EQE, S_EQC, S_NEXT
  } state_t;

  state_t        st;
  logic [1:0]    idx_q, tp_q, ref_q;
  logic [2:0]    lanes_q;
  logic [47:0]   stat_q;
  logic [31:0]   conf_q;
  logic [TW-1:0] cnt_q;
  logic [NW-1:0] tries_q;
  logic          pass_q, done_q, eq_ok_q, cr_lost_q;

  logic [7:0]  max_code;
  logic [2:0]  max_ln, n_sel;
  logic [35:0] need, rate;
  logic        down;
  logic [3:0]  act;
  logic [31:0] conf_new;
  logic        cr_all, abort, eq_ok, cr_lost;
  logic [NW-1:0] tn;

  assign max_code = (src_rate_code < sink_rate_code) ? src_rate_code : sink_rate_code;
  assign max_ln   = (src_lanes < sink_lanes) ? src_lanes : sink_lanes;
  assign need     = 36'(payload_kbs >> 3) * 36'd10;
  assign rate     = (idx_q == 2'd0) ? HI_KBS : LO_KBS;

  always_comb begin
    n_sel = max_ln;
    for (int k = 0; k < 2; k++)
      if (36'(n_sel >> 1) * rate > need) n_sel = n_sel >> 1;
    down = (idx_q == 2'd0) && (36'(n_sel) * LO_KBS > need);
  end

  always_comb begin
    cr_all = 1'b1; abort = 1'b0; eq_ok = stat_q[16]; cr_lost = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] adj;
      act[i] = 3'(i) < lanes_q;
      adj    = stat_q[32 + 4*i +: 4];
      conf_new[8*i +: 8] = act[i] ? {2'b00, adj[3:2] == 2'd3, adj[3:2], adj[1:0] == 2'd3, adj[1:0]} : 8'h00;
      if (act[i] && !stat_q[4*i] && cr_all) begin
        cr_all = 1'b0;
        abort  = conf_q[8*i + 2];
      end
      if (act[i] && !stat_q[4*i]) cr_lost = 1'b1;
      if (act[i] && stat_q[4*i +: 3] != 3'b111) eq_ok = 1'b0;
    end
  end

  assign tn = ((conf_q[1:0] != ref_q) ? NW'(0) : tries_q) + NW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx_q <= 2'd2; tp_q <= 2'd0; ref_q <= 2'd0; lanes_q <= 3'd0;
      stat_q <= '0; conf_q <= '0; cnt_q <= '0; tries_q <= '0;
      pass_q <= 1'b0; done_q <= 1'b0; eq_ok_q <= 1'b0; cr_lost_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pass_q <= 1'b0;
          idx_q  <= (max_code >= 8'd10) ? 2'd0 : (max_code >= 8'd6) ? 2'd1 : 2'd2;
          st     <= S_SEL;
        end
        S_SEL: if (idx_q == 2'd2) begin
          tp_q <= 2'd0; st <= S_TP;
        end else begin
          lanes_q <= n_sel;
          if (down) idx_q <= 2'd1;
          stat_q <= '0;
          st <= S_CFG;
        end
        S_CFG: if (aux_done) begin tp_q <= 2'd1; st <= S_TP; end
        S_TP: if (aux_done) begin
          tries_q <= '0; cnt_q <= '0;
          case (tp_q)
            2'd1:    begin conf_q <= conf_new; ref_q <= 2'd0; st <= S_CRC; end
            2'd2:    st <= S_EQW;
            default: begin done_q <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_CRC: if (aux_done) begin cnt_q <= '0; st <= aux_err ? S_NEXT : S_CRW; end
        S_CRW: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == TW'(CR_WAIT_CYC - 1)) st <= S_CRR;
        end
        S_CRR: if (aux_done) begin
          stat_q <= aux_rdata;
          st <= aux_err ? S_NEXT : S_CRE;
        end
        S_CRE: if (cr_all) begin
          tp_q <= 2'd2; st <= S_TP;
        end else if (abort || tn >= NW'(CR_TRIES)) begin
          st <= S_NEXT;
        end else begin
          ref_q <= conf_q[1:0]; tries_q <= tn; conf_q <= conf_new; st <= S_CRC;
        end
        S_EQW: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == TW'(EQ_WAIT_CYC - 1)) st <= S_EQR;
        end
        S_EQR: if (aux_done) begin
          stat_q <= aux_rdata;
          st <= aux_err ? S_NEXT : S_EQE;
        end
        S_EQE: begin
          eq_ok_q <= eq_ok; cr_lost_q <= cr_lost; conf_q <= conf_new; st <= S_EQC;
        end
        S_EQC: if (aux_done) begin
          cnt_q <= '0;
          if (eq_ok_q) begin
            pass_q <= 1'b1; tp_q <= 2'd0; st <= S_TP;
          end else if (cr_lost_q || aux_err || tries_q + NW'(1) >= NW'(EQ_TRIES)) begin
            st <= S_NEXT;
          end else begin
            tries_q <= tries_q + NW'(1); st <= S_EQW;
          end
        end
        S_NEXT: if (idx_q == 2'd0) begin
          idx_q <= 2'd1; st <= S_SEL;
        end else begin
          tp_q <= 2'd0; st <= S_TP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    aux_req = 1'b0; aux_write = 1'b0; aux_addr = 16'h0000; aux_len = 3'd0; aux_wdata = 32'h0;
    case (st)
      S_CFG: begin
        aux_req = 1'b1; aux_write = 1'b1; aux_addr = 16'h0100; aux_len = 3'd2;
        aux_wdata = {16'h0, sink_enh, 4'b0000, lanes_q, link_rate_code};
      end
      S_TP: begin
        aux_req = 1'b1; aux_write = 1'b1; aux_addr = 16'h0102; aux_len = 3'd1;
        aux_wdata = {30'h0, tp_q};
      end
      S_CRC, S_EQC: begin
        aux_req = 1'b1; aux_write = 1'b1; aux_addr = 16'h0103; aux_len = 3'd4;
        aux_wdata = conf_q;
      end
      S_CRR, S_EQR: begin
        aux_req = 1'b1; aux_addr = 16'h0202; aux_len = 3'd6;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign tx_swing[2*g +: 2]   = conf_q[8*g +: 2];
    assign tx_preemph[2*g +: 2] = conf_q[8*g + 3 +: 2];
  end

  assign tx_pattern     = tp_q;
  assign done           = done_q;
  assign pass           = pass_q;
  assign link_lanes     = lanes_q;
  assign link_rate_code = (idx_q == 2'd0) ? 8'd10 : (idx_q == 2'd1) ? 8'd6 : 8'd0;

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req && !aux_done |=> aux_req && $stable(aux_addr) && $stable(aux_write));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx_pattern == 2'd0);
  p_read_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req && !aux_write |-> aux_addr == 16'h0202 && aux_len == 3'd6);
  p_eq_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EQC |-> tries_q < NW'(EQ_TRIES));
  p_pass_rate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> link_rate_code != 8'd0 && $countones(link_lanes) == 1);
endmodule

// File: tb/test_link_trainer.sv
module test_link_trainer;
  localparam int CRW = 100;
  localparam int EQW = 400;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sink_enh = 1'b0;
  logic [31:0] payload_kbs = 32'd800000;
  logic [7:0]  src_rate_code = 8'd10, sink_rate_code = 8'd10;
  logic [2:0]  src_lanes = 3'd4, sink_lanes = 3'd4;
  logic        aux_req, aux_write, aux_done = 1'b0, aux_err = 1'b0;
  logic [15:0] aux_addr;
  logic [2:0]  aux_len;
  logic [31:0] aux_wdata;
  logic [47:0] aux_rdata = '0;
  logic [1:0]  tx_pattern;
  logic [7:0]  tx_swing, tx_preemph, link_rate_code;
  logic        done, pass;
  logic [2:0]  link_lanes;

  link_trainer #(.CR_WAIT_CYC(CRW), .EQ_WAIT_CYC(EQW)) i_link_trainer (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // sink model and transaction log
  int          n_tx = 0, rd_idx = 0, lat = 0;
  logic [15:0] l_addr [0:63];
  logic [15:0] l_addr_end [0:63];
  logic        l_wr   [0:63];
  logic [2:0]  l_len  [0:63];
  logic [31:0] l_data [0:63];
  int          l_treq [0:63];
  int          l_tdone[0:63];
  logic [15:0] st_p1 = 16'h7777, st_p2 = 16'h7777, adj_lo = 0, adj_hi = 0;
  logic        align_p2 = 1'b1, fail10 = 1'b0;
  int          adj_sw = 0, err_read = -1;
  logic [7:0]  cur_code = 0;
  logic [1:0]  cur_pat = 0;
  logic        busy = 1'b0;

  always @(negedge clk) begin
    if (aux_done) begin
      aux_done = 1'b0; aux_err = 1'b0;
    end else if (busy) begin
      if (lat == 0) begin
        logic bad;
        bad = fail10 && cur_code == 8'd10;
        l_tdone[n_tx-1] = cyc;
        l_addr_end[n_tx-1] = aux_addr;
        if (!l_wr[n_tx-1]) begin
          aux_rdata[15:0]  = bad ? 16'h0 : (cur_pat == 2'd2 ? st_p2 : st_p1);
          aux_rdata[23:16] = (!bad && cur_pat == 2'd2) ? {7'b0, align_p2} : 8'h0;
          aux_rdata[31:24] = 8'h0;
          aux_rdata[47:32] = (rd_idx >= adj_sw) ? adj_hi : adj_lo;
          aux_err = (rd_idx == err_read);
          rd_idx++;
        end
        aux_done = 1'b1; busy = 1'b0;
      end else lat--;
    end else if (aux_req && n_tx < 64) begin
      l_addr[n_tx] = aux_addr; l_wr[n_tx] = aux_write; l_len[n_tx] = aux_len;
      l_data[n_tx] = aux_wdata; l_treq[n_tx] = cyc;
      if (aux_write && aux_addr == 16'h0100) cur_code = aux_wdata[7:0];
      if (aux_write && aux_addr == 16'h0102) cur_pat = aux_wdata[1:0];
      n_tx++; busy = 1'b1; lat = 2;
    end
  end

  task automatic chk(input logic ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int count_addr(input logic [15:0] a, input int lo, input int hi);
    int c = 0;
    for (int i = lo; i < hi && i < n_tx; i++) if (l_addr[i] == a) c++;
    return c;
  endfunction

  function automatic int nth_cfg(input int k);
    int c = 0;
    for (int i = 0; i < n_tx; i++) if (l_addr[i] == 16'h0100) begin
      c++;
      if (c == k) return i;
    end
    return n_tx;
  endfunction

  logic d_pass;
  logic [7:0] d_code;
  logic [2:0] d_lanes;
  int d_cyc;

  task automatic sink_cfg(input logic [15:0] p1, input logic [15:0] p2, input logic al,
                          input logic [15:0] alo, input logic [15:0] ahi, input int sw,
                          input logic f10, input int er);
    st_p1 = p1; st_p2 = p2; align_p2 = al; adj_lo = alo; adj_hi = ahi; adj_sw = sw;
    fail10 = f10; err_read = er;
  endtask

  task automatic run(input logic [31:0] pl, input logic [7:0] sc, input logic [7:0] kc,
                     input logic [2:0] sl, input logic [2:0] kl, input logic enh);
    @(negedge clk);
    n_tx = 0; rd_idx = 0; cur_pat = 0; cur_code = 0;
    payload_kbs = pl; src_rate_code = sc; sink_rate_code = kc;
    src_lanes = sl; sink_lanes = kl; sink_enh = enh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    d_cyc = -1;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done) begin
        d_pass = pass; d_code = link_rate_code; d_lanes = link_lanes; d_cyc = cyc;
        break;
      end
    end
    chk(d_cyc >= 0, "R13 done seen", d_cyc, 1);
    if (d_cyc >= 0) chk(d_cyc == l_tdone[n_tx-1] + 1, "R13 done timing", d_cyc, l_tdone[n_tx-1] + 1);
    chk(l_addr[n_tx-1] == 16'h0102 && l_data[n_tx-1] == 0, "R4 final pattern 0", l_data[n_tx-1], 0);
    @(negedge clk);
    chk(!done, "R13 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!done && !pass && !aux_req, "R1 reset ctrl", {done, pass, aux_req}, 0);
    chk(tx_pattern == 0 && tx_swing == 0 && tx_preemph == 0, "R1 reset drive",
        {tx_pattern, tx_swing, tx_preemph}, 0);
  endtask

  task automatic t_basic;
    sink_cfg(16'h0011, 16'h0077, 1'b1, 16'h9999, 16'h9999, 0, 1'b0, -1);
    run(32'd400000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(d_pass && d_code == 10 && d_lanes == 2, "R9 basic pass", {d_pass, d_code, d_lanes}, {1'b1, 8'd10, 3'd2});
    chk(n_tx == 8, "R7 sequence length", n_tx, 8);
    chk(l_addr[0] == 16'h0100 && l_len[0] == 2 && l_data[0] == 32'h0000020A, "R3 cfg write", l_data[0], 32'h20A);
    chk(l_addr[1] == 16'h0102 && l_data[1] == 1 && l_len[1] == 1, "R4 pattern 1", l_data[1], 1);
    chk(l_addr[2] == 16'h0103 && l_len[2] == 4 && l_data[2] == 0, "R5 first commit zero", l_data[2], 0);
    chk(l_addr[3] == 16'h0202 && !l_wr[3] && l_len[3] == 6, "R6 status read", l_addr[3], 16'h0202);
    chk(l_treq[3] - l_tdone[2] == CRW + 1, "R6 cr wait", l_treq[3] - l_tdone[2], CRW + 1);
    chk(l_addr[4] == 16'h0102 && l_data[4] == 2, "R4 pattern 2", l_data[4], 2);
    chk(l_treq[5] - l_tdone[4] == EQW + 1, "R6 eq wait", l_treq[5] - l_tdone[4], EQW + 1);
    chk(l_addr[6] == 16'h0103 && l_data[6] == 32'h00001111, "R5 eq commit masked", l_data[6], 32'h1111);
    chk(tx_swing == 8'h05 && tx_preemph == 8'h0A, "R5 tx drive", {tx_swing, tx_preemph}, 16'h050A);
    for (int i = 0; i < n_tx; i++)
      chk(l_addr[i] == l_addr_end[i], "R14 address held", l_addr_end[i], l_addr[i]);
  endtask

  task automatic t_select;
    sink_cfg(16'h7777, 16'h7777, 1'b1, 0, 0, 0, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(d_code == 10 && d_lanes == 4 && l_data[0] == 32'h040A, "R2 sel 10x4", l_data[0], 32'h040A);
    run(32'd100000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(d_code == 6 && d_lanes == 1 && l_data[0] == 32'h0106, "R2 sel step down 6x1", l_data[0], 32'h0106);
    run(32'd800000, 8'd10, 8'd6, 3'd4, 3'd2, 1'b1);
    chk(d_code == 6 && d_lanes == 2 && l_data[0] == 32'h8206, "R3 enh 6x2", l_data[0], 32'h8206);
    run(32'd400000, 8'd20, 8'd10, 3'd2, 3'd4, 1'b0);
    chk(d_pass && d_code == 10 && d_lanes == 2, "R2 sel limits 10x2", {d_code, d_lanes}, {8'd10, 3'd2});
    run(32'd400000, 8'd10, 8'd5, 3'd4, 3'd4, 1'b0);
    chk(!d_pass && n_tx == 1 && d_code == 0, "R11 no usable rate", {d_pass, n_tx}, 1);
  endtask

  task automatic t_cr_maxswing;
    sink_cfg(16'h0000, 16'h0000, 1'b0, 16'hFFFF, 16'hFFFF, 0, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(!d_pass && d_code == 6, "R11 fail at lower rate", {d_pass, d_code}, 6);
    chk(count_addr(16'h0103, 0, n_tx) == 4, "R8 max swing abort", count_addr(16'h0103, 0, n_tx), 4);
    chk(l_data[4] == 32'h3F3F3F3F, "R5 max flags", l_data[4], 32'h3F3F3F3F);
  endtask

  task automatic t_cr_tries;
    sink_cfg(16'h0000, 16'h0000, 1'b0, 0, 0, 0, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(count_addr(16'h0103, 0, nth_cfg(2)) == 5, "R8 five tries", count_addr(16'h0103, 0, nth_cfg(2)), 5);
    chk(count_addr(16'h0103, 0, n_tx) == 10 && !d_pass, "R8 tries both rates", count_addr(16'h0103, 0, n_tx), 10);
  endtask

  task automatic t_cr_swing_reset;
    sink_cfg(16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h1111, 2, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(count_addr(16'h0103, 0, nth_cfg(2)) == 8, "R8 swing change resets count",
        count_addr(16'h0103, 0, nth_cfg(2)), 8);
    chk(count_addr(16'h0103, nth_cfg(2), n_tx) == 6, "R8 reset at lower rate",
        count_addr(16'h0103, nth_cfg(2), n_tx), 6);
  endtask

  task automatic t_eq_crlost;
    sink_cfg(16'h1111, 16'h0000, 1'b1, 0, 0, 0, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(!d_pass && count_addr(16'h0202, 0, n_tx) == 4, "R10 cr lost", count_addr(16'h0202, 0, n_tx), 4);
    chk(n_tx == 15, "R10 cr lost sequence", n_tx, 15);
  endtask

  task automatic t_eq_tries(input logic [15:0] p2, input logic al);
    sink_cfg(16'h1111, p2, al, 0, 0, 0, 1'b0, -1);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(!d_pass && count_addr(16'h0202, 0, n_tx) == 14, "R10 six eq tries",
        count_addr(16'h0202, 0, n_tx), 14);
  endtask

  task automatic t_fallback_pass;
    sink_cfg(16'h7777, 16'h7777, 1'b1, 0, 0, 0, 1'b1, -1);
    run(32'd400000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(d_pass && d_code == 6 && d_lanes == 4, "R11 fallback relanes", {d_pass, d_code, d_lanes}, {1'b1, 8'd6, 3'd4});
    chk(l_data[nth_cfg(2)] == 32'h0406, "R11 second cfg", l_data[nth_cfg(2)], 32'h0406);
  endtask

  task automatic t_aux_err;
    sink_cfg(16'h7777, 16'h7777, 1'b1, 0, 0, 0, 1'b0, 0);
    run(32'd800000, 8'd10, 8'd10, 3'd4, 3'd4, 1'b0);
    chk(count_addr(16'h0103, 0, nth_cfg(2)) == 1, "R12 error fails phase",
        count_addr(16'h0103, 0, nth_cfg(2)), 1);
    chk(d_pass && d_code == 6, "R12 pass after error", {d_pass, d_code}, {1'b1, 8'd6});
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_select();
    t_cr_maxswing();
    t_cr_tries();
    t_cr_swing_reset();
    t_eq_crlost();
    t_eq_tries(16'h3333, 1'b1);
    t_eq_tries(16'h7777, 1'b0);
    t_fallback_pass();
    t_aux_err();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule